// File: doc/BRIEF.md
# PHY Register Access Handshake Bridge

This block gives software access to a small bank of PHY configuration registers (delay settings and similar) through a single 32-bit host register. Software loads a PHY address and a data byte into the host register and sets a request bit. The bridge then runs a four-phase request/acknowledge exchange with a PHY-side register file. It reports the acknowledge back in the same host register, so software can poll it.

A write and a read follow the same sequence:
1. Software waits until the acknowledge flag is low.
2. Software sets the write or read request, with the address and data fields held steady.
3. Software waits for the acknowledge flag to rise.
4. Software clears the request.
5. Software waits for the acknowledge flag to drop again.

For a read, the fetched byte is visible in the read-data field while the acknowledge flag is high. The PHY side is modelled as a 64-entry by 8-bit register file. In normal use, addresses 0x00 to 0x08 hold per-mode input delays, 0x0B holds the card clock delay, 0x0C holds the high-speed MMC clock delay and 0x0D holds the strobe delay.

Top module: `phy_port_bridge`

## Requirements
- R1: Host register layout: bit 26 is the acknowledge flag, bit 25 the read request, bit 24 the write request, bits 23:16 the read data, bits 15:8 the write data and bits 5:0 the PHY address. A host write stores only bits 25, 24, 15:8 and 5:0. Bits 31:27, 26, 23:16 and 7:6 ignore host writes; bits 31:27 and 7:6 always read as zero.
- R2: After reset the host register reads 0, the acknowledge flag is low, and every PHY register holds 0.
- R3: When a request bit is captured at a clock edge, the acknowledge flag reads 1 after the third rising edge that follows, and reads 0 after the second.
- R4: While a request bit stays set, the acknowledge flag stays high, and the access is performed once.
- R5: When software clears both request bits, the acknowledge flag reads 0 after the third rising edge that follows, and still reads 1 after the second.
- R6: For a read, the read-data field holds the addressed PHY register's value while the acknowledge flag is high, and it does not change during that time.
- R7: If the write and read requests are set together, the write is performed and the read is ignored: the read-data field keeps its previous value.
- R8: All 64 PHY addresses store independent values, including the delay locations 0x00–0x08, 0x0B, 0x0C and 0x0D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe for the port register |
| host_wr_data | input | 32 | Word written to the port register |
| host_rd_data | output | 32 | Current contents of the port register |

## Verification
The bench first writes and then reads back a table of address/data pairs. The table mixes the delay locations with the lowest and highest addresses, so an address decode fault or a stuck data bit shows up as a wrong byte. Exact-cycle samples around the rise and fall of the acknowledge flag catch a missing or extra pipeline stage. Holding a request bit set past the acknowledge confirms that the acknowledge is held and that the access is not repeated. A word with both request bits set separates write priority from read leakage, and an all-ones idle write exposes any read-only field that can be written.

// File: rtl/phy_port_pkg.sv
package phy_port_pkg;
    localparam int PHY_ADDR_W = 6;
    localparam int PHY_DATA_W = 8;
    localparam int PHY_DEPTH  = 1 << PHY_ADDR_W;
    localparam int HOST_W     = 32;

    localparam int ACK_POS   = 26;
    localparam int RD_POS    = 25;
    localparam int WR_POS    = 24;
    localparam int RDATA_LSB = 16;
    localparam int WDATA_LSB = 8;
    localparam int ADDR_LSB  = 0;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_REQ,
        HS_HOLD,
        HS_REL
    } hs_state_e;

    typedef struct packed {
        logic                  wr;
        logic                  rd;
        logic [PHY_DATA_W-1:0] wdata;
        logic [PHY_ADDR_W-1:0] addr;
    } host_ctl_t;

    typedef struct packed {
        logic                  valid;
        logic                  write;
        logic [PHY_ADDR_W-1:0] addr;
        logic [PHY_DATA_W-1:0] wdata;
    } phy_cmd_t;

    function automatic host_ctl_t unpack_ctl(input logic [HOST_W-1:0] w);
        host_ctl_t c;
        c.wr    = w[WR_POS];
        c.rd    = w[RD_POS];
        c.wdata = w[WDATA_LSB +: PHY_DATA_W];
        c.addr  = w[ADDR_LSB +: PHY_ADDR_W];
        return c;
    endfunction

    function automatic logic [HOST_W-1:0] pack_word(input host_ctl_t c,
                                                     input logic ack,
                                                     input logic [PHY_DATA_W-1:0] rdata);
        logic [HOST_W-1:0] w;
        w = '0;
        w[ACK_POS]                    = ack;
        w[RD_POS]                     = c.rd;
        w[WR_POS]                     = c.wr;
        w[RDATA_LSB +: PHY_DATA_W]    = rdata;
        w[WDATA_LSB +: PHY_DATA_W]    = c.wdata;
        w[ADDR_LSB +: PHY_ADDR_W]     = c.addr;
        return w;
    endfunction
endpackage

// File: rtl/phy_port_reg.sv
module phy_port_reg
    import phy_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [HOST_W-1:0] wr_word,
    output host_ctl_t         ctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (wr_en) begin
            ctl <= unpack_ctl(wr_word);
        end
    end
endmodule

// File: rtl/phy_hs_fsm.sv
module phy_hs_fsm
    import phy_port_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  host_ctl_t             ctl,
    input  logic                  phy_ack,
    input  logic [PHY_DATA_W-1:0] phy_rdata,
    output phy_cmd_t              cmd,
    output logic                  ack_flag,
    output logic [PHY_DATA_W-1:0] rdata_q
);
    hs_state_e state;
    logic      req_any;

    assign req_any = ctl.wr | ctl.rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= HS_IDLE;
            cmd      <= '0;
            ack_flag <= 1'b0;
            rdata_q  <= '0;
        end else begin
            case (state)
                HS_IDLE: begin
                    if (req_any) begin
                        cmd.valid <= 1'b1;
                        cmd.write <= ctl.wr;
                        cmd.addr  <= ctl.addr;
                        cmd.wdata <= ctl.wdata;
                        state     <= HS_REQ;
                    end
                end
                HS_REQ: begin
                    if (phy_ack) begin
                        ack_flag <= 1'b1;
                        if (!cmd.write) begin
                            rdata_q <= phy_rdata;
                        end
                        state <= HS_HOLD;
                    end
                end
                HS_HOLD: begin
                    if (!req_any) begin
                        cmd.valid <= 1'b0;
                        state     <= HS_REL;
                    end
                end
                HS_REL: begin
                    if (!phy_ack) begin
                        ack_flag <= 1'b0;
                        state    <= HS_IDLE;
                    end
                end
                default: state <= HS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/phy_reg_file.sv
module phy_reg_file
    import phy_port_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  phy_cmd_t              cmd,
    output logic                  ack,
    output logic [PHY_DATA_W-1:0] rdata
);
    logic [PHY_DATA_W-1:0] mem [PHY_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PHY_DEPTH; i++) begin
                mem[i] <= '0;
            end
            ack   <= 1'b0;
            rdata <= '0;
        end else if (cmd.valid && !ack) begin
            if (cmd.write) begin
                mem[cmd.addr] <= cmd.wdata;
            end
            rdata <= mem[cmd.addr];
            ack   <= 1'b1;
        end else if (!cmd.valid) begin
            ack <= 1'b0;
        end
    end
endmodule

// File: rtl/phy_port_bridge.sv
module phy_port_bridge
    import phy_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic [HOST_W-1:0] host_wr_data,
    output logic [HOST_W-1:0] host_rd_data
);
    host_ctl_t             ctl;
    phy_cmd_t              phy_cmd;
    logic                  phy_ack;
    logic                  phy_req;
    logic [PHY_DATA_W-1:0] phy_rdata;
    logic                  ack_flag;
    logic [PHY_DATA_W-1:0] rdata_q;

    assign phy_req = phy_cmd.valid;

    phy_port_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (host_wr_en),
        .wr_word (host_wr_data),
        .ctl     (ctl)
    );

    phy_hs_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .phy_ack   (phy_ack),
        .phy_rdata (phy_rdata),
        .cmd       (phy_cmd),
        .ack_flag  (ack_flag),
        .rdata_q   (rdata_q)
    );

    phy_reg_file u_file (
        .clk   (clk),
        .rst   (rst),
        .cmd   (phy_cmd),
        .ack   (phy_ack),
        .rdata (phy_rdata)
    );

    assign host_rd_data = pack_word(ctl, ack_flag, rdata_q);
endmodule

// File: rtl/phy_port_bridge_chk.sv
module phy_port_bridge_chk
    import phy_port_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [HOST_W-1:0] host_rd_data,
    input logic              phy_req,
    input logic              phy_ack
);
    logic                  ack;
    logic                  req_any;
    logic [PHY_DATA_W-1:0] rfield;

    assign ack     = host_rd_data[ACK_POS];
    assign req_any = host_rd_data[WR_POS] | host_rd_data[RD_POS];
    assign rfield  = host_rd_data[RDATA_LSB +: PHY_DATA_W];

    assert_ack_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(req_any));

    assert_phy_ack_after_req_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_ack) |-> $past(phy_req));

    assert_ack_held_R4: assert property (@(posedge clk) disable iff (rst)
        (ack && req_any) |=> ack);

    assert_ack_falls_after_clear_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ack) |-> $past(!req_any));

    assert_phy_release_after_ack_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(phy_req) |-> $past(ack));

    assert_rdata_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (ack && $past(ack)) |-> $stable(rfield));
endmodule

bind phy_port_bridge phy_port_bridge_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_rd_data (host_rd_data),
    .phy_req      (phy_req),
    .phy_ack      (phy_ack)
);

// File: tb/phy_port_bridge_tb.sv
module phy_port_bridge_tb;
    import phy_port_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic [31:0] host_rd_data;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    phy_port_bridge u_dut (
        .clk          (clk),
        .rst          (rst),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .host_rd_data (host_rd_data)
    );

    localparam int NVEC = 8;
    localparam logic [13:0] VEC [NVEC] = '{
        {6'h00, 8'h11}, {6'h08, 8'h88}, {6'h0B, 8'hB3}, {6'h0C, 8'hC4},
        {6'h0D, 8'h5D}, {6'h3F, 8'hFE}, {6'h21, 8'h01}, {6'h07, 8'h80}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic wr, input logic rd,
                                       input logic [5:0] a, input logic [7:0] d);
        logic [31:0] w;
        w = '0;
        w[24] = wr;
        w[25] = rd;
        w[15:8] = d;
        w[5:0] = a;
        return w;
    endfunction

    task automatic host_write(input logic [31:0] w);
        @(negedge clk);
        host_wr_en   = 1'b1;
        host_wr_data = w;
        @(negedge clk);
        host_wr_en   = 1'b0;
    endtask

    task automatic wait_ack(input logic lvl, input string tag);
        int n = 0;
        while (host_rd_data[26] !== lvl && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(tag, {31'b0, host_rd_data[26]}, {31'b0, lvl});
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d);
        host_write(mk(1'b1, 1'b0, a, d));
        wait_ack(1'b1, "R3 write ack rise");
        host_write(mk(1'b0, 1'b0, a, d));
        wait_ack(1'b0, "R5 write ack fall");
    endtask

    task automatic do_read(input logic [5:0] a, output logic [7:0] d);
        host_write(mk(1'b0, 1'b1, a, 8'h00));
        wait_ack(1'b1, "R3 read ack rise");
        d = host_rd_data[23:16];
        @(negedge clk);
        chk("R6 rdata stable while ack", {24'b0, host_rd_data[23:16]}, {24'b0, d});
        host_write(mk(1'b0, 1'b0, a, 8'h00));
        wait_ack(1'b0, "R5 read ack fall");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        logic [7:0] prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 reset word", host_rd_data, 32'h0);

        // R1: idle write with every non-request bit set
        host_write(32'hFCFF_A5FF);
        chk("R1 writable fields only", host_rd_data, 32'h0000_A53F);
        repeat (4) @(negedge clk);
        chk("R1 no access without request", {31'b0, host_rd_data[26]}, 32'h0);

        // R2: PHY file reset to zero
        do_read(6'h05, rv);
        chk("R2 reset entry 0x05", {24'b0, rv}, 32'h0);
        do_read(6'h3F, rv);
        chk("R2 reset entry 0x3F", {24'b0, rv}, 32'h0);

        // R3/R4/R5 exact timing on a write
        host_write(mk(1'b1, 1'b0, 6'h02, 8'h3C));
        @(negedge clk);
        @(negedge clk);
        chk("R3 ack low after two edges", {31'b0, host_rd_data[26]}, 32'h0);
        @(negedge clk);
        chk("R3 ack high after three edges", {31'b0, host_rd_data[26]}, 32'h1);
        repeat (6) @(negedge clk);
        chk("R4 ack held while request set", {31'b0, host_rd_data[26]}, 32'h1);
        host_write(mk(1'b0, 1'b0, 6'h02, 8'h3C));
        @(negedge clk);
        @(negedge clk);
        chk("R5 ack high two edges after clear", {31'b0, host_rd_data[26]}, 32'h1);
        @(negedge clk);
        chk("R5 ack low three edges after clear", {31'b0, host_rd_data[26]}, 32'h0);
        do_read(6'h02, rv);
        chk("R4 held write stored once", {24'b0, rv}, 32'h3C);

        // R8/R6: table walk
        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i][13:8], VEC[i][7:0]);
        end
        for (int i = 0; i < NVEC; i++) begin
            do_read(VEC[i][13:8], rv);
            chk($sformatf("R8 R6 readback addr %0h", VEC[i][13:8]),
                {24'b0, rv}, {24'b0, VEC[i][7:0]});
        end

        // R7: both requests set, write wins
        prev = host_rd_data[23:16];
        host_write(mk(1'b1, 1'b1, 6'h0D, 8'h5A));
        wait_ack(1'b1, "R7 ack rise");
        chk("R7 read ignored", {24'b0, host_rd_data[23:16]}, {24'b0, prev});
        host_write(mk(1'b0, 1'b0, 6'h0D, 8'h5A));
        wait_ack(1'b0, "R7 ack fall");
        do_read(6'h0D, rv);
        chk("R7 write performed", {24'b0, rv}, 32'h5A);
        do_read(6'h0C, rv);
        chk("R8 neighbour untouched", {24'b0, rv}, 32'hC4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule